// File: doc/BRIEF.md
# CAN Message-Object Interrupt Arbiter

This block holds the control state of fifteen CAN message objects and turns their receive and transmit events into one interrupt identifier for a host CPU. Each object has two control bytes. Every flag in them is a two-bit field. A host write can set the flag, reset it, or leave it as it is, so one byte write can change some flags and keep the others. The block does not send or receive frames on the bus. It only keeps the flags and ranks the pending interrupt sources.

The host uses a byte-wide register bus with an address, write data, a write enable and a combinational read path. The CAN side gives one receive pulse and one transmit pulse per object, and a status-change pulse. The host reads the identifier register to find the highest-ranked pending source. It acknowledges an object by writing the reset code to that object's pending field. It acknowledges the status source by writing any value to the identifier address. A global enable bit gates the interrupt output pin.

Address map: address 0 is the global control byte, with bit 0 as the interrupt enable. Address 1 is the identifier. Object n (1 to 15) has control byte 0 at address 2n and control byte 1 at address 2n+1. In the vectors `rxEvent` and `txEvent`, bit k belongs to object k+1.

Top module: `can_irq_arbiter`

## Requirements
- R1: After reset, every object control byte reads 0x55, the identifier reads 0, the global control byte reads 0, and `irqOut` is low.
- R2: In a written field, code 2'b10 sets the flag and 2'b01 resets it. Codes 2'b11 and 2'b00 leave the flag unchanged. On read, each field returns 2'b10 when its flag is true and 2'b01 when it is false. Control byte 0 has valid in bits [1:0], transmit enable in [3:2], receive enable in [5:4] and pending in [7:6]. Control byte 1 has new data in [1:0], lost/updating in [3:2], transmit request in [5:4] and remote pending in [7:6].
- R3: A field written with the unchanged code keeps its value, while the other fields written in the same byte are updated.
- R4: A receive pulse on a valid object sets new data. If new data was already set, the pulse also sets lost. If receive enable is set, the pulse also sets pending.
- R5: A transmit pulse on a valid object clears its transmit request. If transmit enable is set, the pulse also sets pending.
- R6: An event on an object whose valid flag is clear changes no flag. An event whose matching enable is clear does not set pending.
- R7: The identifier is 0 when nothing is pending, 1 for status change, 2 for object 15, and n+2 for object n from 1 to 14.
- R8: The identifier always names the highest-ranked pending source. Status change ranks first, then object 15, then objects 1 to 14 with the lower number first.
- R9: An object's pending flag is cleared only by the reset code in its pending field. Writing that code again has no further effect. A status-change pulse sets the status source, and only a write to address 1 clears it.
- R10: `irqOut` is high exactly when the global enable is set and the identifier is nonzero. The global enable has no effect on the identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 5 | Register byte address |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| rxEvent | input | 15 | Receive-complete pulse, one bit per object |
| txEvent | input | 15 | Transmit-complete pulse, one bit per object |
| statusEvent | input | 1 | Status-change pulse |
| irqOut | output | 1 | Interrupt request to the host |

## Verification
The assertions assume that every change to a pending flag comes either from an enabled event or from a bus write to that object's control byte 0. They also assume that the event inputs are clean and synchronous to `clk`. The stimulus drives events and bus writes one at a time, on the falling edge, so the same flag is never set and reset in the same cycle. Several objects are pulsed together only when the test is about priority ranking.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int OBJ_IDX_W = 4;
  localparam int DATA_W = 8;
  localparam int ID_W = 8;
  localparam logic [1:0] FLD_SET = 2'b10;
  localparam logic [1:0] FLD_RST = 2'b01;

  typedef enum logic [1:0] {RD_NONE, RD_GLB, RD_ID, RD_OBJ} rdKind_t;

  typedef struct packed {
    logic objWr;
    logic byteSel;
    logic [OBJ_IDX_W-1:0] objNum;
    logic glbWr;
    logic statClr;
    logic [DATA_W-1:0] data;
    rdKind_t rdKind;
    logic rdByte;
    logic [OBJ_IDX_W-1:0] rdObj;
  } busStrb_t;

  function automatic logic applyFld(logic cur, logic [1:0] code);
    if (code == FLD_SET) return 1'b1;
    if (code == FLD_RST) return 1'b0;
    return cur;
  endfunction

  function automatic logic [1:0] encFld(logic f);
    return f ? FLD_SET : FLD_RST;
  endfunction
endpackage

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 15,
  parameter int ADDR_W = OBJ_IDX_W + 1
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output busStrb_t          strb
);
  logic [OBJ_IDX_W-1:0] objIdx;
  logic byteSel;

  assign objIdx = regAddr[ADDR_W-1:1];
  assign byteSel = regAddr[0];

  always_comb begin
    strb = '0;
    strb.data = regWrData;
    if (objIdx == '0) begin
      if (!byteSel) begin
        strb.rdKind = RD_GLB;
        strb.glbWr = regWrEn;
      end else begin
        strb.rdKind = RD_ID;
        strb.statClr = regWrEn;
      end
    end else if (int'(objIdx) <= NUM_OBJ) begin
      strb.rdKind = RD_OBJ;
      strb.rdObj = objIdx;
      strb.rdByte = byteSel;
      strb.objWr = regWrEn;
      strb.objNum = objIdx;
      strb.byteSel = byteSel;
    end
  end
endmodule

// File: rtl/can_irq_datapath.sv
module can_irq_datapath
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrb_t           strb,
  input  logic [NUM_OBJ-1:0] rxEvent,
  input  logic [NUM_OBJ-1:0] txEvent,
  input  logic               statusEvent,
  output logic [DATA_W-1:0]  regRdData,
  output logic [ID_W-1:0]    intId,
  output logic [NUM_OBJ-1:0] pendVec,
  output logic               statPend,
  output logic               gieBit,
  output logic               irqOut
);
  logic [NUM_OBJ-1:0] msgVal, txIe, rxIe, intPnd;
  logic [NUM_OBJ-1:0] newDat, msgLst, txReq, rmtPnd;
  logic [NUM_OBJ-1:0] hit0, hit1, rxHit, txHit;
  logic [OBJ_IDX_W-1:0] rIdx;

  for (genvar k = 0; k < NUM_OBJ; k++) begin : g_dec
    assign hit0[k] = strb.objWr && !strb.byteSel && (strb.objNum == OBJ_IDX_W'(k + 1));
    assign hit1[k] = strb.objWr && strb.byteSel && (strb.objNum == OBJ_IDX_W'(k + 1));
  end

  assign rxHit = rxEvent & msgVal;
  assign txHit = txEvent & msgVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgVal <= '0; txIe <= '0; rxIe <= '0; intPnd <= '0;
      newDat <= '0; msgLst <= '0; txReq <= '0; rmtPnd <= '0;
      gieBit <= 1'b0;
      statPend <= 1'b0;
    end else begin
      for (int k = 0; k < NUM_OBJ; k++) begin
        if (hit0[k]) begin
          msgVal[k] <= applyFld(msgVal[k], strb.data[1:0]);
          txIe[k] <= applyFld(txIe[k], strb.data[3:2]);
          rxIe[k] <= applyFld(rxIe[k], strb.data[5:4]);
        end
        intPnd[k] <= (hit0[k] ? applyFld(intPnd[k], strb.data[7:6]) : intPnd[k])
                     | (rxHit[k] && rxIe[k]) | (txHit[k] && txIe[k]);
        newDat[k] <= (hit1[k] ? applyFld(newDat[k], strb.data[1:0]) : newDat[k]) | rxHit[k];
        msgLst[k] <= (hit1[k] ? applyFld(msgLst[k], strb.data[3:2]) : msgLst[k])
                     | (rxHit[k] && newDat[k]);
        txReq[k] <= !txHit[k] && (hit1[k] ? applyFld(txReq[k], strb.data[5:4]) : txReq[k]);
        rmtPnd[k] <= hit1[k] ? applyFld(rmtPnd[k], strb.data[7:6]) : rmtPnd[k];
      end
      if (strb.glbWr) gieBit <= strb.data[0];
      statPend <= statusEvent || (statPend && !strb.statClr);
    end
  end

  always_comb begin
    intId = '0;
    for (int k = NUM_OBJ - 2; k >= 0; k--) begin
      if (intPnd[k]) intId = ID_W'(k + 3);
    end
    if (intPnd[NUM_OBJ-1]) intId = ID_W'(2);
    if (statPend) intId = ID_W'(1);
  end

  assign rIdx = strb.rdObj - 1'b1;

  always_comb begin
    unique case (strb.rdKind)
      RD_GLB: regRdData = {{(DATA_W-1){1'b0}}, gieBit};
      RD_ID: regRdData = intId;
      RD_OBJ:
        if (!strb.rdByte)
          regRdData = {encFld(intPnd[rIdx]), encFld(rxIe[rIdx]),
                       encFld(txIe[rIdx]), encFld(msgVal[rIdx])};
        else
          regRdData = {encFld(rmtPnd[rIdx]), encFld(txReq[rIdx]),
                       encFld(msgLst[rIdx]), encFld(newDat[rIdx])};
      default: regRdData = '0;
    endcase
  end

  assign pendVec = intPnd;
  assign irqOut = gieBit && (intId != '0);
endmodule

// File: rtl/can_irq_arbiter.sv
module can_irq_arbiter
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 15,
  localparam int ADDR_W = OBJ_IDX_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_OBJ-1:0] rxEvent,
  input  logic [NUM_OBJ-1:0] txEvent,
  input  logic               statusEvent,
  output logic               irqOut
);
  busStrb_t strb;
  logic [ID_W-1:0] intId;
  logic [NUM_OBJ-1:0] pendVec;
  logic statPend;
  logic gieBit;

  can_irq_ctrl #(.NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W)) uCtrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .strb(strb)
  );

  can_irq_datapath #(.NUM_OBJ(NUM_OBJ)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxEvent(rxEvent), .txEvent(txEvent),
    .statusEvent(statusEvent), .regRdData(regRdData), .intId(intId),
    .pendVec(pendVec), .statPend(statPend), .gieBit(gieBit), .irqOut(irqOut)
  );
endmodule

// File: rtl/can_irq_arbiter_chk.sv
module can_irq_arbiter_chk
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 15,
  parameter int ADDR_W = OBJ_IDX_W + 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [1:0]         pndCode,
  input logic               statusEvent,
  input logic               irqOut,
  input logic               gieBit,
  input logic [ID_W-1:0]    intId,
  input logic [NUM_OBJ-1:0] pendVec,
  input logic               statPend
);
  // R8
  stat_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusEvent |=> (intId == ID_W'(1)));

  // R8
  stat_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    statPend |-> (intId == ID_W'(1)));

  // R7
  top_obj_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec[NUM_OBJ-1] && !statPend) |-> (intId == ID_W'(2)));

  // R7
  idle_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec == '0) && !statPend) == (intId == '0));

  // R10
  gated_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!gieBit || intId == '0) |-> !irqOut);

  // R10
  raised_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gieBit && intId != '0) |-> irqOut);

  for (genvar k = 0; k < NUM_OBJ; k++) begin : g_ack
    // R9
    pend_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pendVec[k]) |-> $past(regWrEn && (regAddr == {OBJ_IDX_W'(k + 1), 1'b0})
                                  && (pndCode == FLD_RST)));
  end
endmodule

bind can_irq_arbiter can_irq_arbiter_chk #(.NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .pndCode(regWrData[7:6]), .statusEvent(statusEvent), .irqOut(irqOut),
  .gieBit(gieBit), .intId(intId), .pendVec(pendVec), .statPend(statPend)
);

// File: tb/sim_can_irq_arbiter.sv
module sim_can_irq_arbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [14:0] rxEvent = '0;
  logic [14:0] txEvent = '0;
  logic statusEvent = 1'b0;
  logic irqOut;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  can_irq_arbiter u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .rxEvent(rxEvent),
    .txEvent(txEvent), .statusEvent(statusEvent), .irqOut(irqOut)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(string req, logic [4:0] a, logic [7:0] exp);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic pulse(logic [14:0] rx, logic [14:0] tx, logic st);
    @(negedge clk);
    rxEvent = rx; txEvent = tx; statusEvent = st;
    @(negedge clk);
    rxEvent = '0; txEvent = '0; statusEvent = 1'b0;
  endtask

  task automatic t_reset;
    rdChk("R1 obj1 ctrl0", 5'd2, 8'h55);
    rdChk("R1 obj15 ctrl1", 5'd31, 8'h55);
    rdChk("R1 identifier", 5'd1, 8'h00);
    rdChk("R1 global", 5'd0, 8'h00);
    check("R1 irqOut", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic t_codes;
    wr(5'd6, 8'hFE);
    rdChk("R2 set valid", 5'd6, 8'h56);
    wr(5'd6, 8'h00);
    rdChk("R2 code 00 unchanged", 5'd6, 8'h56);
    wr(5'd6, 8'hFD);
    rdChk("R2 reset valid", 5'd6, 8'h55);
  endtask

  task automatic t_partial;
    wr(5'd9, 8'hEE);
    rdChk("R3 two fields set", 5'd9, 8'h66);
    wr(5'd9, 8'hFD);
    rdChk("R3 only new data reset", 5'd9, 8'h65);
  endtask

  task automatic t_rx;
    wr(5'd10, 8'hEE);
    pulse(15'h0010, '0, 1'b0);
    rdChk("R4 pending set", 5'd10, 8'hA6);
    rdChk("R4 new data set", 5'd11, 8'h56);
    rdChk("R4 id obj5", 5'd1, 8'd7);
    pulse(15'h0010, '0, 1'b0);
    rdChk("R4 lost on overrun", 5'd11, 8'h5A);
    wr(5'd10, 8'h7F);
    rdChk("R4 cleared", 5'd1, 8'd0);
  endtask

  task automatic t_tx;
    wr(5'd12, 8'hFA);
    wr(5'd13, 8'hEF);
    rdChk("R5 tx request set", 5'd13, 8'h65);
    pulse('0, 15'h0020, 1'b0);
    rdChk("R5 tx request cleared", 5'd13, 8'h55);
    rdChk("R5 pending set", 5'd12, 8'h9A);
    rdChk("R5 id obj6", 5'd1, 8'd8);
    wr(5'd12, 8'h7F);
  endtask

  task automatic t_ignore;
    wr(5'd14, 8'hEF);
    pulse(15'h0040, 15'h0040, 1'b0);
    rdChk("R6 invalid ctrl0", 5'd14, 8'h65);
    rdChk("R6 invalid ctrl1", 5'd15, 8'h55);
    rdChk("R6 invalid id", 5'd1, 8'd0);
    wr(5'd16, 8'hFE);
    pulse('0, 15'h0080, 1'b0);
    rdChk("R6 disabled ctrl0", 5'd16, 8'h56);
    rdChk("R6 disabled id", 5'd1, 8'd0);
  endtask

  task automatic t_prio;
    wr(5'd4, 8'hEE);
    wr(5'd18, 8'hEE);
    wr(5'd30, 8'hEE);
    pulse(15'h4102, '0, 1'b0);
    rdChk("R7 obj15 id 2", 5'd1, 8'd2);
    wr(5'd30, 8'h7F);
    rdChk("R8 obj2 next", 5'd1, 8'd4);
    pulse('0, '0, 1'b1);
    rdChk("R8 status first", 5'd1, 8'd1);
    wr(5'd1, 8'h00);
    rdChk("R9 status cleared", 5'd1, 8'd4);
    wr(5'd4, 8'h7F);
    rdChk("R8 obj9 next", 5'd1, 8'd11);
    wr(5'd18, 8'hFF);
    rdChk("R9 unchanged keeps pending", 5'd1, 8'd11);
    wr(5'd18, 8'h7F);
    rdChk("R9 ack", 5'd1, 8'd0);
    wr(5'd18, 8'h7F);
    rdChk("R9 second ack harmless id", 5'd1, 8'd0);
    rdChk("R9 second ack harmless ctrl0", 5'd18, 8'h66);
    wr(5'd2, 8'hEE);
    wr(5'd28, 8'hEE);
    pulse(15'h2000, '0, 1'b0);
    rdChk("R7 obj14 id 16", 5'd1, 8'd16);
    pulse(15'h0001, '0, 1'b0);
    rdChk("R8 obj1 over obj14", 5'd1, 8'd3);
    wr(5'd2, 8'h7F);
    wr(5'd28, 8'h7F);
  endtask

  task automatic t_gie;
    pulse(15'h0100, '0, 1'b0);
    check("R10 no irq when disabled", {7'd0, irqOut}, 8'h00);
    rdChk("R10 id ungated", 5'd1, 8'd11);
    wr(5'd0, 8'h01);
    check("R10 irq when enabled", {7'd0, irqOut}, 8'h01);
    rdChk("R10 global reads 1", 5'd0, 8'h01);
    wr(5'd18, 8'h7F);
    check("R10 irq drops", {7'd0, irqOut}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_codes();
    t_partial();
    t_rx();
    t_tx();
    t_ignore();
    t_prio();
    t_gie();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule